// File: doc/BRIEF.md
# Memory-Mapped GPIO Line Controller with Per-Line Interrupts

A single bank of up to 64 general-purpose lines behind a 64-bit register port. Software drives lines through an output latch. The latch has atomic set and clear registers, so one write changes only the bits that hold ones. Each line has a configuration register. It selects output enable, open-drain drive, input polarity inversion, interrupt enable, edge or level sensing, an input qualification filter and a pin-function field. When the pin-function field is nonzero, the line is taken away from GPIO use.

Every pad input goes through its own filter instance, then through the per-line polarity inversion. The result feeds two places: the input data register and an interrupt cell. Each interrupt cell keeps a pending bit and an enable bit. Separate write-one-to-set and write-one-to-clear controls act on each bit. A line's interrupt output is high when that line has pending, enable and the configuration interrupt-enable bit all set.

The filter runs as a two-state machine. In `F_STEADY` the filtered value is settled. On a sample tick where the synchronised input differs, it either takes the new value at once (count 0) or moves to `F_QUAL`. In `F_QUAL`, a sample that matches the old value returns to `F_STEADY` and changes nothing. A run of count+1 differing samples takes the new value and returns to `F_STEADY`. The edge detector in each interrupt cell is a two-state machine. It goes from `E_LOW` to `E_HIGH` when the polarity-adjusted input is 1 and from `E_HIGH` to `E_LOW` when it is 0. A rising event is the `E_LOW` state seen together with input 1.

Top module: `gpio_line_ctl`

## Requirements
- R1: After reset the output latch, all configuration fields, pending bits and enable bits are zero, so pad_oe, pad_out and irq are all zero.
- R2: A read of offset 0x90 returns the line count in bits [7:0] and the base interrupt vector index in bits [15:8]. All other bits read 0.
- R3: Each one bit in a word written to offset 0x8 sets that latch bit, and each one bit written to offset 0x10 clears it. Zero bits leave their lines alone. A read of 0x8 or 0x10 returns the latch.
- R4: The configuration register of line i is at 0x400+8*i. Its fields are: bit0 output enable, bit1 polarity invert, bit2 interrupt enable, bit3 type (1 edge, 0 level), bits[7:4] filter count, bits[11:8] filter rate, bit12 open-drain and bits[25:16] pin function. Only these bits read back. Lines at or beyond the line count read 0 and ignore writes.
- R5: On a GPIO line in push-pull mode, pad_oe equals bit0 and pad_out equals the latch bit. In open-drain mode, pad_out is 0 and pad_oe is bit0 AND NOT latch.
- R6: On a line whose pin-function field is nonzero, pad_oe and pad_out are 0 and set/clear writes do not change its latch bit.
- R7: A read of offset 0x0 returns, per line, the filtered pad input XOR the polarity-invert bit.
- R8: With filter rate S and count C, the input is sampled once every 2^S clocks. A new level reaches the filtered value only after C+1 consecutive samples show it, so a pulse seen by fewer samples is dropped.
- R9: The interrupt register of line i is at 0x800+8*i. In edge mode its pending bit (bit0) is set by a 0-to-1 change of the polarity-adjusted input. Writing bit1 sets pending and writing bit0 clears it. Setting the invert bit turns falling pad edges into events.
- R10: In level mode pending is set on every cycle the polarity-adjusted input is 1. A clear written while the level is active has no effect. Pending stays set after the level drops, until it is cleared.
- R11: Writing bit3 of the interrupt register sets the enable and writing bit2 clears it. If both are written together the set wins. Reads return enable in bit3 and pending in bit0.
- R12: irq[i] is pending AND enable AND configuration bit2 of line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| pad_in | input | NUM_LINES | Pad input samples |
| pad_out | output | NUM_LINES | Pad output value |
| pad_oe | output | NUM_LINES | Pad output enable |
| irq | output | NUM_LINES | Per-line interrupt outputs |

## Verification
The hardest cases to reach are the ones where a pending bit must hold against a clear. In level mode a clear is written while the qualified level is still active. In edge mode the polarity-invert bit is changed while the pad is high, which must not create an event. The stimulus brings each line into these states by holding a pad steady long enough for the filter to settle. It reprograms the line's configuration in the middle of the sequence, then reads the interrupt register back through the bus. The filter rejection case uses a rate of one sample per two clocks and a pulse three clocks wide, so fewer than the required three samples ever see it.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 64;
    localparam int CFG_W    = 26;

    localparam logic [ADDR_W-1:0] OFF_RX    = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_SET   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_CONST = 12'h090;

    localparam logic [1:0] REGION_GLOB = 2'd0;
    localparam logic [1:0] REGION_CFG  = 2'd1;
    localparam logic [1:0] REGION_INT  = 2'd2;

    localparam logic [CFG_W-1:0] CFG_WMASK = 26'h3FF_1FFF;

    localparam int INT_PEND_W1C = 0;
    localparam int INT_PEND_W1S = 1;
    localparam int INT_ENA_W1C  = 2;
    localparam int INT_ENA_W1S  = 3;

    typedef struct packed {
        logic [9:0] pin_fn;
        logic [2:0] rsv;
        logic       od;
        logic [3:0] frate;
        logic [3:0] fcnt;
        logic       edge_type;
        logic       int_en;
        logic       invert;
        logic       oe;
    } line_cfg_t;

    typedef enum logic {F_STEADY = 1'b0, F_QUAL = 1'b1} filt_state_e;
    typedef enum logic {E_LOW = 1'b0, E_HIGH = 1'b1} edge_state_e;

endpackage

// File: rtl/gl_filter.sv
module gl_filter
    import gpio_ctl_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic [3:0] qual_cnt,
    input  logic [3:0] rate_sel,
    output logic       filt_out
);

    logic               sync_q;
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] rate_mask;
    logic               tick;
    filt_state_e        st_q, st_d;
    logic [3:0]         run_q, run_d;
    logic               filt_q, filt_d;

    always_comb begin
        rate_mask = (PRESC_W'(1) << rate_sel) - PRESC_W'(1);
        tick      = (presc_q & rate_mask) == rate_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            sync_q  <= 1'b0;
        end else begin
            presc_q <= presc_q + PRESC_W'(1);
            sync_q  <= raw_in;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_STEADY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        run_d  = run_q;
        filt_d = filt_q;
        if (tick) begin
            unique case (st_q)
                F_STEADY: begin
                    if (sync_q != filt_q) begin
                        if (qual_cnt == 4'd0) begin
                            filt_d = sync_q;
                        end else begin
                            run_d = 4'd1;
                            st_d  = F_QUAL;
                        end
                    end
                end
                F_QUAL: begin
                    if (sync_q == filt_q) begin
                        run_d = 4'd0;
                        st_d  = F_STEADY;
                    end else if (run_q >= qual_cnt) begin
                        filt_d = sync_q;
                        run_d  = 4'd0;
                        st_d   = F_STEADY;
                    end else begin
                        run_d = run_q + 4'd1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 4'd0;
            filt_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            filt_q <= filt_d;
        end
    end

    assign filt_out = filt_q;

endmodule

// File: rtl/gl_irq_cell.sv
module gl_irq_cell
    import gpio_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sense,
    input  logic       edge_mode,
    input  logic       wr_stb,
    input  logic [3:0] wr_bits,
    output logic       pend,
    output logic       ena
);

    edge_state_e st_q, st_d;
    logic        rise;
    logic        set_hit;
    logic        pend_q, pend_d;
    logic        ena_q, ena_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= E_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        unique case (st_q)
            E_LOW: begin
                if (sense) begin
                    rise = 1'b1;
                    st_d = E_HIGH;
                end
            end
            E_HIGH: begin
                if (!sense) st_d = E_LOW;
            end
        endcase
    end

    always_comb begin
        set_hit = edge_mode ? rise : sense;
        pend_d  = (pend_q & ~(wr_stb & wr_bits[INT_PEND_W1C]))
                | set_hit
                | (wr_stb & wr_bits[INT_PEND_W1S]);
        ena_d   = ena_q;
        if (wr_stb && wr_bits[INT_ENA_W1S])      ena_d = 1'b1;
        else if (wr_stb && wr_bits[INT_ENA_W1C]) ena_d = 1'b0;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ena_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            ena_q  <= ena_d;
        end
    end

    assign pend = pend_q;
    assign ena  = ena_q;

endmodule

// File: rtl/gl_pad_drive.sv
module gl_pad_drive #(
    parameter int LINES = 16
) (
    input  logic [LINES-1:0] is_gpio,
    input  logic [LINES-1:0] oe_en,
    input  logic [LINES-1:0] od_en,
    input  logic [LINES-1:0] drive_val,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe
);

    for (genvar i = 0; i < LINES; i++) begin : g_pad
        always_comb begin
            if (!is_gpio[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = 1'b0;
            end else if (od_en[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = oe_en[i] & ~drive_val[i];
            end else begin
                pad_out[i] = drive_val[i];
                pad_oe[i]  = oe_en[i];
            end
        end
    end

endmodule

// File: rtl/gpio_line_ctl.sv
module gpio_line_ctl
    import gpio_ctl_pkg::*;
#(
    parameter int         NUM_LINES = 16,
    parameter logic [7:0] VEC_BASE  = 8'h30,
    parameter int         PRESC_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] irq
);

    localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    line_cfg_t            cfg_q [NUM_LINES];
    logic [NUM_LINES-1:0] latch_q;
    logic [NUM_LINES-1:0] filt, adj, pend, ena;
    logic [NUM_LINES-1:0] is_gpio, oe_en, od_on;
    logic [NUM_LINES-1:0] cfg_wr, int_wr;
    logic [NUM_LINES-1:0] wmask;

    logic                 wr, rd, aligned, line_ok;
    logic                 wr_set, wr_clr;
    logic [1:0]           region;
    logic [6:0]           lidx;
    logic [LIDX_W-1:0]    lsel;
    logic [DATA_W-1:0]    rd_data;
    logic                 rsp_valid_q;
    logic [DATA_W-1:0]    rsp_rdata_q;

    // request decode
    always_comb begin
        wr      = req_valid & req_write;
        rd      = req_valid & ~req_write;
        aligned = req_addr[2:0] == 3'b000;
        region  = req_addr[11:10];
        lidx    = req_addr[9:3];
        lsel    = lidx[LIDX_W-1:0];
        line_ok = int'(lidx) < NUM_LINES;
        wr_set  = wr && (req_addr == OFF_SET);
        wr_clr  = wr && (req_addr == OFF_CLR);
        wmask   = req_wdata[NUM_LINES-1:0] & is_gpio;
    end

    // output latch, only GPIO lines are touched
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_set) latch_q <= latch_q | wmask;
        else if (wr_clr) latch_q <= latch_q & ~wmask;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign cfg_wr[i] = wr && aligned && (region == REGION_CFG) && (int'(lidx) == i);
        assign int_wr[i] = wr && aligned && (region == REGION_INT) && (int'(lidx) == i);

        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q[i] <= '0;
            else if (cfg_wr[i]) cfg_q[i] <= line_cfg_t'(req_wdata[CFG_W-1:0] & CFG_WMASK);
        end

        gl_filter #(
            .PRESC_W (PRESC_W)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pad_in[i]),
            .qual_cnt (cfg_q[i].fcnt),
            .rate_sel (cfg_q[i].frate),
            .filt_out (filt[i])
        );

        assign adj[i]     = filt[i] ^ cfg_q[i].invert;
        assign is_gpio[i] = cfg_q[i].pin_fn == 10'd0;
        assign oe_en[i]   = cfg_q[i].oe;
        assign od_on[i]   = cfg_q[i].od;

        gl_irq_cell u_irq (
            .clk       (clk),
            .rst_n     (rst_n),
            .sense     (adj[i]),
            .edge_mode (cfg_q[i].edge_type),
            .wr_stb    (int_wr[i]),
            .wr_bits   (req_wdata[3:0]),
            .pend      (pend[i]),
            .ena       (ena[i])
        );

        assign irq[i] = pend[i] & ena[i] & cfg_q[i].int_en;
    end

    gl_pad_drive #(
        .LINES (NUM_LINES)
    ) u_pad (
        .is_gpio   (is_gpio),
        .oe_en     (oe_en),
        .od_en     (od_on),
        .drive_val (latch_q),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (region)
            REGION_GLOB: begin
                if (req_addr == OFF_RX)
                    rd_data = DATA_W'(adj);
                else if (req_addr == OFF_SET || req_addr == OFF_CLR)
                    rd_data = DATA_W'(latch_q);
                else if (req_addr == OFF_CONST)
                    rd_data = DATA_W'({VEC_BASE, 8'(NUM_LINES)});
            end
            REGION_CFG: begin
                if (line_ok && aligned) rd_data = DATA_W'(cfg_q[lsel]);
            end
            REGION_INT: begin
                if (line_ok && aligned)
                    rd_data = DATA_W'({ena[lsel], 2'b00, pend[lsel]});
            end
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd;
            rsp_rdata_q <= rd ? rd_data : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/gpio_line_ctl_chk.sv
module gpio_line_ctl_chk
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [DATA_W-1:0]    req_wdata,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_LINES-1:0] latch,
    input logic [NUM_LINES-1:0] is_gpio,
    input logic [NUM_LINES-1:0] od_on,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] ena
);

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_SET)
        |=> ((latch & $past(req_wdata[NUM_LINES-1:0] & is_gpio))
             == $past(req_wdata[NUM_LINES-1:0] & is_gpio)));

    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_CLR)
        |=> ((latch & $past(req_wdata[NUM_LINES-1:0] & is_gpio)) == '0));

    p_od_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & od_on) == '0);

    p_fn_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & ~is_gpio) == '0);

    p_fn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch ^ $past(latch)) & ~$past(is_gpio)) == '0);

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~(pend & ena)) == '0);

endmodule

bind gpio_line_ctl gpio_line_ctl_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .latch     (latch_q),
    .is_gpio   (is_gpio),
    .od_on     (od_on),
    .pend      (pend),
    .ena       (ena)
);

// File: tb/test_gpio_line_ctl.sv
module test_gpio_line_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [N-1:0]  m_latch;
    logic [25:0]   m_cfg [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_line_ctl i_gpio_line_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 64'hDEAD;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] cfg_a(input int i);
        return 12'h400 + 12'(8 * i);
    endfunction

    function automatic logic [11:0] int_a(input int i);
        return 12'h800 + 12'(8 * i);
    endfunction

    function automatic logic [N-1:0] gpio_mask();
        logic [N-1:0] g;
        for (int i = 0; i < N; i++) g[i] = (m_cfg[i][25:16] == 10'd0);
        return g;
    endfunction

    function automatic logic [N-1:0] exp_oe();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            if (m_cfg[i][25:16] != 10'd0) v[i] = 1'b0;
            else if (m_cfg[i][12])        v[i] = m_cfg[i][0] & ~m_latch[i];
            else                          v[i] = m_cfg[i][0];
        end
        return v;
    endfunction

    function automatic logic [N-1:0] exp_out();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++)
            v[i] = (m_cfg[i][25:16] == 10'd0) && !m_cfg[i][12] && m_latch[i];
        return v;
    endfunction

    task automatic set_cfg(input int i, input logic [25:0] v);
        m_cfg[i] = v;
        bus_wr(cfg_a(i), 64'(v));
    endtask

    task automatic clean_all();
        for (int i = 0; i < N; i++) set_cfg(i, 26'd0);
        pad_in = '0;
        bus_wr(12'h010, '1);
        m_latch = '0;
        settle(6);
        for (int i = 0; i < N; i++) bus_wr(int_a(i), 64'h5);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d;
        void'($urandom(32'd20240917));
        m_latch = '0;
        for (int i = 0; i < N; i++) m_cfg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);
        chk("R1 pad_out", 64'(pad_out), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        bus_rd(12'h008, d); chk("R1 latch", d, 64'd0);
        bus_rd(cfg_a(3), d); chk("R1 cfg", d, 64'd0);

        // R2 constants
        bus_rd(12'h090, d); chk("R2 const", d, 64'h3010);

        // R4 configuration field mask and range
        bus_wr(cfg_a(5), '1);
        bus_rd(cfg_a(5), d); chk("R4 cfg readback", d, 64'h3FF_1FFF);
        bus_wr(cfg_a(5), 64'd0);
        bus_wr(cfg_a(20), '1);
        bus_rd(cfg_a(20), d); chk("R4 out of range", d, 64'd0);

        // R3 R5 R6 random drive
        for (int it = 0; it < 80; it++) begin
            int op = int'($urandom_range(0, 2));
            if (op == 0) begin
                int ln = int'($urandom_range(0, N - 1));
                logic [25:0] v = '0;
                v[0]  = 1'($urandom);
                v[12] = 1'($urandom);
                if ($urandom_range(0, 3) == 0) v[25:16] = 10'($urandom_range(1, 1023));
                set_cfg(ln, v);
            end else begin
                logic [N-1:0] mk = N'($urandom);
                if (op == 1) m_latch = m_latch | (mk & gpio_mask());
                else         m_latch = m_latch & ~(mk & gpio_mask());
                bus_wr(op == 1 ? 12'h008 : 12'h010, 64'(mk));
            end
            chk("R5 pad_oe", 64'(pad_oe), 64'(exp_oe()));
            chk("R5 pad_out", 64'(pad_out), 64'(exp_out()));
            bus_rd(it[0] ? 12'h008 : 12'h010, d);
            chk("R3 latch readback", d, 64'(m_latch));
        end

        // R6 directed: non-GPIO line ignores set and clear
        set_cfg(2, 26'h001_0001);
        m_latch[2] = 1'b0;
        bus_wr(12'h010, 64'h4);
        m_latch[2] = 1'b0;
        bus_rd(12'h008, d);
        bus_wr(12'h008, 64'h4);
        bus_rd(12'h008, d); chk("R6 latch unchanged", 64'(d[2]), 64'd0);
        chk("R6 pad quiet", 64'({pad_oe[2], pad_out[2]}), 64'd0);
        set_cfg(2, 26'h000_0001);
        bus_wr(12'h008, 64'h4); m_latch[2] = 1'b1;
        chk("R6 gpio again drives", 64'({pad_oe[2], pad_out[2]}), 64'h3);

        clean_all();

        // R7 input register with polarity invert
        for (int it = 0; it < 8; it++) begin
            logic [N-1:0] inv = N'($urandom);
            for (int i = 0; i < N; i++) set_cfg(i, {24'd0, inv[i], 1'b0});
            pad_in = N'($urandom);
            settle(5);
            bus_rd(12'h000, d);
            chk("R7 input data", d, 64'(pad_in ^ inv));
        end

        clean_all();

        // R8 filter: rate 1 (every 2 clocks), count 2 (3 samples)
        set_cfg(0, 26'h120);
        settle(8);
        pad_in[0] = 1'b1; settle(3); pad_in[0] = 1'b0;
        settle(20);
        bus_rd(12'h000, d); chk("R8 short pulse dropped", 64'(d[0]), 64'd0);
        pad_in[0] = 1'b1; settle(20);
        bus_rd(12'h000, d); chk("R8 long level passes", 64'(d[0]), 64'd1);
        pad_in[0] = 1'b0;

        clean_all();

        // R9 edge mode on line 4
        set_cfg(4, 26'hC);
        bus_wr(int_a(4), 64'h1);
        bus_wr(int_a(4), 64'h8);
        chk("R9 idle irq", 64'(irq[4]), 64'd0);
        pad_in[4] = 1'b1; settle(5);
        chk("R9 rising edge irq", 64'(irq[4]), 64'd1);
        bus_rd(int_a(4), d); chk("R9 pending after rise", d, 64'h9);
        bus_wr(int_a(4), 64'h1);
        bus_rd(int_a(4), d); chk("R9 clear holds in edge mode", d, 64'h8);
        bus_wr(int_a(4), 64'h2);
        bus_rd(int_a(4), d); chk("R9 software set", d, 64'h9);
        bus_wr(int_a(4), 64'h1);
        set_cfg(4, 26'hE);
        settle(3);
        bus_rd(int_a(4), d); chk("R9 invert change no event", d, 64'h8);
        pad_in[4] = 1'b0; settle(5);
        bus_rd(int_a(4), d); chk("R9 falling edge via invert", d, 64'h9);
        chk("R9 falling irq", 64'(irq[4]), 64'd1);

        // R10 level mode on line 6
        set_cfg(6, 26'h4);
        bus_wr(int_a(6), 64'h9);
        bus_rd(int_a(6), d); chk("R10 idle level", d, 64'h8);
        pad_in[6] = 1'b1; settle(5);
        chk("R10 level irq", 64'(irq[6]), 64'd1);
        bus_wr(int_a(6), 64'h1);
        bus_rd(int_a(6), d); chk("R10 reasserts while active", d, 64'h9);
        pad_in[6] = 1'b0; settle(5);
        bus_rd(int_a(6), d); chk("R10 sticky after drop", d, 64'h9);
        bus_wr(int_a(6), 64'h1);
        bus_rd(int_a(6), d); chk("R10 cleared", d, 64'h8);
        chk("R10 irq low", 64'(irq[6]), 64'd0);

        // R11 enable controls
        bus_wr(int_a(6), 64'h4);
        bus_rd(int_a(6), d); chk("R11 enable cleared", d, 64'h0);
        bus_wr(int_a(6), 64'h2);
        chk("R11 masked irq", 64'(irq[6]), 64'd0);
        bus_wr(int_a(6), 64'hC);
        bus_rd(int_a(6), d); chk("R11 set wins", d, 64'h9);
        chk("R11 irq after enable", 64'(irq[6]), 64'd1);

        // R12 configuration interrupt enable gates output
        set_cfg(6, 26'h0);
        chk("R12 cfg gate", 64'(irq[6]), 64'd0);
        bus_rd(int_a(6), d); chk("R12 state kept", d, 64'h9);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule